// File: doc/BRIEF.md
# Glyph ROM Index Port

This block sits on a processor's byte-wide I/O bus and gives it access to a glyph ROM organised as pairs of bytes. Software first loads a 16-bit glyph index by writing its upper and lower bytes to two index registers, each of which also answers at a second, alias offset. It then reads the two bytes of the selected row through two data ports: one returns the even ROM byte (index times two), the other the odd ROM byte (index times two plus one).

The ROM is external and synchronous with one cycle of read latency. The block drives the ROM address and enable during the request cycle. It returns the data, together with a read-valid strobe, in the following cycle. A presence input tells the block whether a ROM is fitted. When no ROM is fitted, index writes are dropped and data reads return all ones without touching the ROM.

Top module: `glyph_rom_port`

## Requirements
- R1: After reset the index is zero and `cpu_rvalid` and `rom_en` are low; a first even-byte read addresses ROM byte 0.
- R2: A write to offset 0x20 loads the upper index byte and leaves the lower byte unchanged.
- R3: A write to offset 0x21 loads the lower index byte and leaves the upper byte unchanged.
- R4: Offsets 0x2C and 0x2D act for writes exactly as 0x20 and 0x21 respectively.
- R5: A read at offset 0x22 with the ROM present raises `rom_en` in the same cycle with `rom_addr` equal to index×2.
- R6: A read at offset 0x23 with the ROM present raises `rom_en` in the same cycle with `rom_addr` equal to index×2+1.
- R7: Every read at one of the six decoded offsets (0x20, 0x21, 0x22, 0x23, 0x2C, 0x2D) raises `cpu_rvalid` for one cycle in the next cycle. For a data read with the ROM present, `cpu_rdata` then equals the ROM byte at the requested address.
- R8: While `rom_present` is low, index writes leave the index unchanged and `rom_en` stays low.
- R9: While `rom_present` is low, data reads at 0x22 and 0x23 return 0xFF with `cpu_rvalid`.
- R10: Reads of the index registers (0x20, 0x21, 0x2C, 0x2D) return 0xFF with `cpu_rvalid` and do not enable the ROM.
- R11: Reads and writes at any other offset raise no `cpu_rvalid`, leave `rom_en` low and leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | I/O offset of the access |
| cpu_wdata | input | 8 | Write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe, one cycle per read |
| cpu_rdata | output | 8 | Read data, valid with `cpu_rvalid` |
| cpu_rvalid | output | 1 | Read-data strobe, one cycle after a decoded read |
| rom_present | input | 1 | High when a glyph ROM is fitted |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 17 | ROM byte address |
| rom_data | input | 8 | ROM read data, one cycle after `rom_en` |

## Verification
The index is loaded through primary and alias offsets in mixed order with distinct byte values, so a swapped byte lane or a dead alias shows up in the next data read address. Both data ports are read back to back for several indices, including 0x0000 and 0xFFFF, which separates the even and odd byte selection and exposes a dropped top or bottom bit. The presence input is lowered between writes and reads, which tells dropped writes apart from accepted ones and checks the 0xFF return. Index-register reads and accesses to unused offsets check that only the six decoded offsets produce a strobe.

// File: rtl/glyph_rom_pkg.sv
// Shared types for the glyph ROM index port.
package glyph_rom_pkg;

    // Register decoded from an I/O offset.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IDX_HI,
        SEL_IDX_LO,
        SEL_DATA_EVEN,
        SEL_DATA_ODD
    } port_sel_e;

endpackage

// File: rtl/glyph_addr_decode.sv
// Decodes an I/O offset into one of the block's registers.
// Assumes: offsets are distinct; the alias offsets are decoded only when ALIAS_EN is set.
module glyph_addr_decode
    import glyph_rom_pkg::*;
#(
    parameter int          OFF_W    = 8,
    parameter logic [7:0]  OFF_HI   = 8'h20,
    parameter logic [7:0]  OFF_LO   = 8'h21,
    parameter logic [7:0]  OFF_EVEN = 8'h22,
    parameter logic [7:0]  OFF_ODD  = 8'h23,
    parameter logic [7:0]  OFF_AHI  = 8'h2C,
    parameter logic [7:0]  OFF_ALO  = 8'h2D,
    parameter bit          ALIAS_EN = 1'b1
) (
    input  logic [OFF_W-1:0] addr,
    output port_sel_e        sel
);

    logic alias_hi;
    logic alias_lo;

    generate
        if (ALIAS_EN) begin : g_alias
            assign alias_hi = (addr == OFF_W'(OFF_AHI));
            assign alias_lo = (addr == OFF_W'(OFF_ALO));
        end else begin : g_no_alias
            assign alias_hi = 1'b0;
            assign alias_lo = 1'b0;
        end
    endgenerate

    // Map the offset to a register selector.
    always_comb begin
        sel = SEL_NONE;
        if (addr == OFF_W'(OFF_HI) || alias_hi)      sel = SEL_IDX_HI;
        else if (addr == OFF_W'(OFF_LO) || alias_lo) sel = SEL_IDX_LO;
        else if (addr == OFF_W'(OFF_EVEN))           sel = SEL_DATA_EVEN;
        else if (addr == OFF_W'(OFF_ODD))            sel = SEL_DATA_ODD;
    end

endmodule

// File: rtl/glyph_index_latch.sv
// Holds the glyph index, loaded a byte at a time.
// Assumes: IDX_W is between DATA_W+1 and 2*DATA_W; writes are dropped when no ROM is fitted.
module glyph_index_latch
    import glyph_rom_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  port_sel_e         sel,
    input  logic              present,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  index
);

    localparam int HI_W = IDX_W - DATA_W;

    // Load the selected index byte on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index <= '0;
        end else if (wr && present) begin
            if (sel == SEL_IDX_HI) index[IDX_W-1:DATA_W] <= wdata[HI_W-1:0];
            if (sel == SEL_IDX_LO) index[DATA_W-1:0]     <= wdata;
        end
    end

endmodule

// File: rtl/glyph_read_path.sv
// Issues ROM reads and returns read data one cycle after the request.
// Assumes: the ROM returns data the cycle after rom_en; the return select is registered with the strobe.
module glyph_read_path
    import glyph_rom_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  port_sel_e         sel,
    input  logic              present,
    input  logic [IDX_W-1:0]  index,
    input  logic [DATA_W-1:0] rom_data,
    output logic              rom_en,
    output logic [IDX_W:0]    rom_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic is_data;
    logic is_reg;
    logic use_rom_q;

    // Classify the access for this cycle.
    always_comb begin
        is_data = (sel == SEL_DATA_EVEN) || (sel == SEL_DATA_ODD);
        is_reg  = (sel != SEL_NONE);
    end

    assign rom_en   = rd && is_data && present;
    assign rom_addr = {index, (sel == SEL_DATA_ODD)};

    // Register the strobe and the data source for the return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid    <= 1'b0;
            use_rom_q <= 1'b0;
        end else begin
            rvalid    <= rd && is_reg;
            use_rom_q <= rom_en;
        end
    end

    assign rdata = use_rom_q ? rom_data : {DATA_W{1'b1}};

endmodule

// File: rtl/glyph_rom_port.sv
// Top of the glyph ROM index port: decode, index latch and read path.
// Assumes: one access per cycle, never a read and a write in the same cycle.
module glyph_rom_port
    import glyph_rom_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              rom_present,
    output logic              rom_en,
    output logic [IDX_W:0]    rom_addr,
    input  logic [DATA_W-1:0] rom_data
);

    port_sel_e        sel;
    logic [IDX_W-1:0] index;

    glyph_addr_decode #(.OFF_W(OFF_W)) u_decode (
        .addr (cpu_addr),
        .sel  (sel)
    );

    glyph_index_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cpu_wr),
        .sel     (sel),
        .present (rom_present),
        .wdata   (cpu_wdata),
        .index   (index)
    );

    glyph_read_path #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (cpu_rd),
        .sel      (sel),
        .present  (rom_present),
        .index    (index),
        .rom_data (rom_data),
        .rom_en   (rom_en),
        .rom_addr (rom_addr),
        .rdata    (cpu_rdata),
        .rvalid   (cpu_rvalid)
    );

endmodule

// File: rtl/glyph_rom_port_chk.sv
// Port-level properties of the glyph ROM index port, bound to the top.
module glyph_rom_port_chk #(
    parameter int IDX_W  = 16,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  cpu_addr,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              cpu_rvalid,
    input logic              rom_present,
    input logic              rom_en,
    input logic [IDX_W:0]    rom_addr
);

    logic data_off;
    logic idx_off;
    assign data_off = (cpu_addr == OFF_W'(8'h22)) || (cpu_addr == OFF_W'(8'h23));
    assign idx_off  = (cpu_addr == OFF_W'(8'h20)) || (cpu_addr == OFF_W'(8'h21)) ||
                      (cpu_addr == OFF_W'(8'h2C)) || (cpu_addr == OFF_W'(8'h2D));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cpu_rvalid));

    assert_even_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && cpu_addr == OFF_W'(8'h22)) |-> (rom_addr[0] == 1'b0));

    assert_odd_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_en && cpu_addr == OFF_W'(8'h23)) |-> (rom_addr[0] == 1'b1));

    assert_strobe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (data_off || idx_off)) |=> cpu_rvalid);

    assert_absent_no_rom_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_present |-> !rom_en);

    assert_absent_index_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_present || !cpu_wr) |=> $stable(rom_addr[IDX_W:1]));

    assert_absent_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && data_off && !rom_present) |=> (cpu_rdata == {DATA_W{1'b1}}));

    assert_index_read_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && idx_off) |=> (cpu_rdata == {DATA_W{1'b1}}));

    assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !data_off && !idx_off) |=> !cpu_rvalid);

endmodule

bind glyph_rom_port glyph_rom_port_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_wr      (cpu_wr),
    .cpu_rd      (cpu_rd),
    .cpu_rdata   (cpu_rdata),
    .cpu_rvalid  (cpu_rvalid),
    .rom_present (rom_present),
    .rom_en      (rom_en),
    .rom_addr    (rom_addr)
);

// File: tb/test_glyph_rom_port.sv
// Cycle-by-cycle reference model bench for the glyph ROM index port.
module test_glyph_rom_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid;
    logic        rom_present = 1'b1;
    logic        rom_en;
    logic [16:0] rom_addr;
    logic [7:0]  rom_data = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state.
    int   m_idx = 0;
    bit   exp_v = 1'b0;
    int   exp_d = 0;

    always #5 clk = ~clk;

    glyph_rom_port i_glyph_rom_port (
        .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
        .cpu_wr (cpu_wr), .cpu_rd (cpu_rd), .cpu_rdata (cpu_rdata), .cpu_rvalid (cpu_rvalid),
        .rom_present (rom_present), .rom_en (rom_en), .rom_addr (rom_addr), .rom_data (rom_data)
    );

    function automatic int rom_byte(int a);
        return ((a * 37) ^ (a >> 9) ^ 8'h5A) & 8'hFF;
    endfunction

    // Synchronous ROM model.
    always @(posedge clk) if (rom_en) rom_data <= 8'(rom_byte(int'(rom_addr)));

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: check last return, drive, check ROM side, update model.
    task automatic cyc(bit wr, bit rd, int addr, int wdata, bit pres, string req);
        bit is_data, is_idx, en_exp;
        int a_exp;
        @(negedge clk);
        check({req, " rvalid"}, int'(cpu_rvalid), int'(exp_v));
        if (exp_v) check({req, " rdata"}, int'(cpu_rdata), exp_d);
        cpu_wr = wr; cpu_rd = rd; cpu_addr = 8'(addr); cpu_wdata = 8'(wdata); rom_present = pres;
        #1;
        is_data = (addr == 'h22) || (addr == 'h23);
        is_idx  = (addr == 'h20) || (addr == 'h21) || (addr == 'h2C) || (addr == 'h2D);
        en_exp  = rd && is_data && pres;
        a_exp   = m_idx * 2 + ((addr == 'h23) ? 1 : 0);
        check({req, " rom_en"}, int'(rom_en), int'(en_exp));
        if (en_exp) check({req, " rom_addr"}, int'(rom_addr), a_exp);
        exp_v = rd && (is_data || is_idx);
        exp_d = en_exp ? rom_byte(a_exp) : 'hFF;
        if (wr && pres) begin
            if (addr == 'h20 || addr == 'h2C) m_idx = (m_idx & 'hFF) | ((wdata & 'hFF) << 8);
            if (addr == 'h21 || addr == 'h2D) m_idx = (m_idx & 'hFF00) | (wdata & 'hFF);
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rvalid", int'(cpu_rvalid), 0);
        check("R1 rom_en", int'(rom_en), 0);
        rst_n = 1'b1;
        cyc(0, 1, 'h22, 0, 1, "R1");
        cyc(0, 1, 'h23, 0, 1, "R6");
        cyc(1, 0, 'h20, 'h3C, 1, "R2");
        cyc(0, 1, 'h22, 0, 1, "R2");
        cyc(1, 0, 'h21, 'hA5, 1, "R3");
        cyc(0, 1, 'h22, 0, 1, "R3");
        cyc(0, 1, 'h23, 0, 1, "R7");
        cyc(1, 0, 'h2C, 'h71, 1, "R4");
        cyc(0, 1, 'h23, 0, 1, "R4");
        cyc(1, 0, 'h2D, 'h0E, 1, "R4");
        cyc(0, 1, 'h22, 0, 1, "R5");
        cyc(1, 0, 'h20, 'hFF, 1, "R2");
        cyc(1, 0, 'h21, 'hFF, 1, "R3");
        cyc(0, 1, 'h23, 0, 1, "R6");
        cyc(0, 1, 'h22, 0, 1, "R5");
        cyc(1, 0, 'h20, 'h12, 0, "R8");
        cyc(1, 0, 'h2D, 'h34, 0, "R8");
        cyc(0, 1, 'h22, 0, 0, "R9");
        cyc(0, 1, 'h23, 0, 0, "R9");
        cyc(0, 1, 'h23, 0, 1, "R8");
        for (int i = 0; i < 4; i++) cyc(0, 1, 'h20 + ((i < 2) ? i : 10 + i), 0, 1, "R10");
        cyc(1, 0, 'h24, 'h00, 1, "R11");
        cyc(1, 0, 'h1F, 'h00, 1, "R11");
        cyc(0, 1, 'h2E, 0, 1, "R11");
        cyc(0, 1, 'h00, 0, 1, "R11");
        cyc(0, 1, 'h22, 0, 1, "R11");
        cyc(1, 0, 'h21, 'h00, 1, "R3");
        cyc(1, 0, 'h20, 'h00, 1, "R2");
        cyc(0, 1, 'h22, 0, 1, "R5");
        cyc(0, 1, 'h23, 0, 1, "R6");
        cyc(0, 0, 'h00, 0, 1, "R7");
        cyc(0, 0, 'h00, 0, 1, "R7");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule